// File: doc/BRIEF.md
# Fractional Occupancy Status Flags

This block tracks how many words a FIFO holds and turns that count into four active-low status flags: full, empty, more-than-half-full, and a single "near an edge" flag that is low when the FIFO is nearly empty or nearly full. The FIFO it serves reports a write through a one-cycle `inc` pulse and a read through a one-cycle `dec` pulse. The block keeps its own occupancy counter from those pulses.

All thresholds are fixed fractions of the `DEPTH` parameter: one eighth, one half and seven eighths. They therefore scale with the depth. `DEPTH` must be a power of two and at least 16, and elaboration stops otherwise. When several FIFOs are chained, the pin that carries the near-edge flag is used for chaining instead. Driving `cascade` high then holds the near-edge flag deasserted, and the other three flags keep working. The event pulses are plain single-cycle strobes with no handshake. The FIFO that owns the storage is responsible for not issuing real writes while full or real reads while empty, and this block ignores such pulses.

Top module: `aflag_status`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the occupancy is 0, `full_n`=1, `half_n`=1, `empty_n`=0 and `almost_n`=0 (with `cascade`=0).
- R2: `empty_n` is 0 exactly when the occupancy is 0.
- R3: `full_n` is 0 exactly when the occupancy equals `DEPTH`.
- R4: `half_n` is 0 exactly when the occupancy is strictly greater than `DEPTH/2` (129 or more for a depth of 256).
- R5: With `cascade`=0, `almost_n` is 0 when the occupancy is below `DEPTH/8` or above `7*DEPTH/8`. It is 1 from `DEPTH/8` to `7*DEPTH/8` inclusive (for 256 words: low on 0..31 and 225..256).
- R6: With `cascade`=1, `almost_n` is 1 at every occupancy, and the other three flags are unaffected.
- R7: A pulse on `inc` or `dec` sampled at a rising clock edge changes the flags at that same edge, one cycle after the pulse is presented. Before that edge the flags still show the old occupancy.
- R8: When `inc` and `dec` are both 1 in the same cycle, the occupancy and the flags are unchanged.
- R9: An `inc` pulse while the occupancy equals `DEPTH` is ignored: a following `dec` leaves `DEPTH-1` words.
- R10: A `dec` pulse while the occupancy is 0 is ignored: a following `inc` leaves 1 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| inc | input | 1 | One-cycle pulse, one word written |
| dec | input | 1 | One-cycle pulse, one word read |
| cascade | input | 1 | 1 = chained configuration, near-edge flag held high |
| full_n | output | 1 | Low when the FIFO holds DEPTH words |
| empty_n | output | 1 | Low when the FIFO holds no words |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |
| almost_n | output | 1 | Low in the bottom-eighth and top-eighth bands |

## Verification
The only internal state is the occupancy counter. A wrong count is invisible while it stays within the same band, and it shows at the ports only when a threshold is crossed one step early or late. The bench therefore walks the count one word at a time through every boundary: 31/32, 128/129, 224/225, 0 and DEPTH. It compares all four flags at each step, so a miscount shows within one cycle of the crossing where it matters. Ignored pulses at full and at empty leave no trace at that moment. They are checked one step later, when the opposite pulse must move the flag back.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic over_half;
    logic edge_band;
  } occ_cond_t;

  function automatic bit depth_legal(int d);
    return (d >= 16) && ((d & (d - 1)) == 0);
  endfunction

endpackage

// File: rtl/aflag_occ_counter.sv
module aflag_occ_counter #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt_next
);

  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          grow;
  logic          shrink;

  // a lone inc grows unless already at the top; a lone dec shrinks unless at zero
  assign grow   = inc && !dec && (cnt_q != TOP);
  assign shrink = dec && !inc && (cnt_q != '0);

  always_comb begin
    cnt_next = cnt_q;
    if (grow)
      cnt_next = cnt_q + 1'b1;
    else if (shrink)
      cnt_next = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_next;
  end

endmodule

// File: rtl/aflag_band_decode.sv
module aflag_band_decode
  import aflag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] cnt,
  output occ_cond_t     cond
);

  localparam logic [CW-1:0] TOP     = CW'(DEPTH);
  localparam logic [CW-1:0] LOW_LIM = CW'(DEPTH / 8);
  localparam logic [CW-1:0] MID     = CW'(DEPTH / 2);
  localparam logic [CW-1:0] HIGH_LIM = CW'((7 * DEPTH) / 8);

  always_comb begin
    cond.full      = (cnt == TOP);
    cond.empty     = (cnt == '0);
    cond.over_half = (cnt > MID);
    cond.edge_band = (cnt < LOW_LIM) || (cnt > HIGH_LIM);
  end

endmodule

// File: rtl/aflag_flag_regs.sv
module aflag_flag_regs
  import aflag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  occ_cond_t cond,
  output logic      full_n,
  output logic      empty_n,
  output logic      half_n,
  output logic      edge_n
);

  // reset values match the decode of an empty FIFO
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      edge_n  <= 1'b0;
    end else begin
      full_n  <= !cond.full;
      empty_n <= !cond.empty;
      half_n  <= !cond.over_half;
      edge_n  <= !cond.edge_band;
    end
  end

endmodule

// File: rtl/aflag_status.sv
module aflag_status
  import aflag_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic cascade,
  output logic full_n,
  output logic empty_n,
  output logic half_n,
  output logic almost_n
);

  localparam int CW = $clog2(DEPTH) + 1;

  generate
    if (!depth_legal(DEPTH)) begin : g_bad_depth
      $error("aflag_status: DEPTH must be a power of two of at least 16");
    end
  endgenerate

  logic [CW-1:0] cnt_next;
  occ_cond_t     cond;
  logic          edge_n;

  aflag_occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .dec      (dec),
    .cnt_next (cnt_next)
  );

  aflag_band_decode #(.DEPTH(DEPTH), .CW(CW)) u_dec (
    .cnt  (cnt_next),
    .cond (cond)
  );

  aflag_flag_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (cond),
    .full_n  (full_n),
    .empty_n (empty_n),
    .half_n  (half_n),
    .edge_n  (edge_n)
  );

  // R6: chained configuration keeps the near-edge flag deasserted
  assign almost_n = edge_n | cascade;

endmodule

// File: rtl/aflag_status_chk.sv
module aflag_status_chk (
  input logic clk,
  input logic rst_n,
  input logic inc,
  input logic dec,
  input logic cascade,
  input logic full_n,
  input logic empty_n,
  input logic half_n,
  input logic almost_n
);

  // R2
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));

  // R4
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);

  // R5
  empty_implies_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !cascade) |-> !almost_n);

  // R6
  cascade_edge_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade |-> almost_n);

  // R8
  both_pulses_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> ($stable(full_n) && $stable(empty_n) && $stable(half_n)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> ($stable(full_n) && $stable(empty_n) && $stable(half_n)));

  // R9
  write_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && inc && !dec) |=> !full_n);

  // R10
  read_at_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && dec && !inc) |=> !empty_n);

endmodule

bind aflag_status aflag_status_chk u_chk (.*);

// File: tb/aflag_status_bench.sv
module aflag_status_bench;

  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b0;
  logic dec = 1'b0;
  logic cascade = 1'b0;
  logic full_n, empty_n, half_n, almost_n;

  int checks = 0;
  int errors = 0;
  int occ = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aflag_status #(.DEPTH(DEPTH)) u_aflag_status (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .cascade(cascade),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .almost_n(almost_n)
  );

  function automatic logic exp_full_n(int c);  return !(c == DEPTH); endfunction
  function automatic logic exp_empty_n(int c); return !(c == 0); endfunction
  function automatic logic exp_half_n(int c);  return !(c > DEPTH / 2); endfunction
  function automatic logic exp_almost_n(int c, logic casc);
    if (casc) return 1'b1;
    return (c >= DEPTH / 8) && (c <= (7 * DEPTH) / 8);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s occ=%0d actual=%b expected=%b", tag, occ, act, exp);
    end
  endtask

  task automatic chk_all(string ctx);
    chk({"R2 empty_n ", ctx}, empty_n, exp_empty_n(occ));
    chk({"R3 full_n ", ctx}, full_n, exp_full_n(occ));
    chk({"R4 half_n ", ctx}, half_n, exp_half_n(occ));
    chk({cascade ? "R6 almost_n " : "R5 almost_n ", ctx}, almost_n, exp_almost_n(occ, cascade));
  endtask

  // present inc/dec for one cycle, confirm no early change, then check after the edge
  task automatic step(logic i, logic d);
    @(negedge clk);
    inc = i;
    dec = d;
    #1;
    chk("R7 before edge full_n", full_n, exp_full_n(occ));
    chk("R7 before edge empty_n", empty_n, exp_empty_n(occ));
    chk("R7 before edge half_n", half_n, exp_half_n(occ));
    @(posedge clk);
    #2;
    if (i && !d && occ < DEPTH) occ++;
    else if (d && !i && occ > 0) occ--;
    chk_all("after edge");
    @(negedge clk);
    inc = 1'b0;
    dec = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset full_n", full_n, 1'b1);
    chk("R1 reset half_n", half_n, 1'b1);
    chk("R1 reset empty_n", empty_n, 1'b0);
    chk("R1 reset almost_n", almost_n, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 first cycle empty_n", empty_n, 1'b0);
    chk("R1 first cycle almost_n", almost_n, 1'b0);

    // R10: read at empty is ignored, next write leaves one word
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R10 one word after ignored read", empty_n, 1'b1);
    chk("R10 low band at one word", almost_n, 1'b0);

    // walk up through every boundary to full
    while (occ < DEPTH) step(1'b1, 1'b0);
    chk("R3 reached full", full_n, 1'b0);

    // R9: write at full ignored, one read leaves DEPTH-1
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    chk("R9 not full after ignored write", full_n, 1'b1);
    chk("R9 still top band", almost_n, 1'b0);
    step(1'b1, 1'b0);

    // R8: simultaneous pulses at full, at mid and at empty
    step(1'b1, 1'b1);
    chk("R8 full kept", full_n, 1'b0);

    // R6: cascade while walking down across the upper boundary
    cascade = 1'b1;
    repeat (40) step(1'b0, 1'b1);
    cascade = 1'b0;
    #1;
    chk("R6 release restores edge flag", almost_n, exp_almost_n(occ, 1'b0));

    while (occ > DEPTH / 2) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R8 mid count kept", half_n, 1'b1);
    step(1'b1, 1'b0);
    chk("R4 129 words", half_n, 1'b0);

    while (occ > 0) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R8 empty kept", empty_n, 1'b0);

    // random phases with a drifting bias to visit both ends
    for (int ph = 0; ph < 8; ph++) begin
      int bias = (ph % 2 == 0) ? 75 : 25;
      cascade = (ph == 5);
      for (int n = 0; n < 500; n++) begin
        int r1 = $urandom_range(99);
        int r2 = $urandom_range(99);
        step(r1 < bias, r2 < (100 - bias));
      end
    end
    cascade = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule